// File: doc/BRIEF.md
# Dual-Channel Serial Converter Front End

This block is the digital input side of a two-channel, 12-bit digital-to-analog converter. A host sends 14-bit words over a three-wire serial link made of a serial clock, a data line and an active-low select. Each word carries a two-bit channel address followed by a 12-bit code. A separate active-low load strobe moves the code from the shift register into one channel register or both. The two-bit address chooses the target.

The channel registers act as level-sensitive latches. While the load strobe is low, every addressed register follows the data field of the shift register. While the strobe is high, both registers keep their values, so a new word can be shifted in without disturbing the codes in use. The two held codes are the block's outputs and drive the converter switches. Codes use straight binary: 0x000 is zero scale, 0x800 is midscale and 0xFFF is full scale.

The design runs on a fast system clock. All four serial-side inputs pass through a synchronizer of at least two flops. The rising edge of the serial clock is detected after synchronization.

Top module: `dacif_dual_front`

## Requirements
- R1: While the asynchronous reset is active, both channel codes read 0x000, and the shift register is cleared.
- R2: A frame is 14 bits sent most significant bit first. Bit 13 is the first address bit (A1), bit 12 is the second (A0), and bits 11..0 are the code, D11 first. A loaded code appears at the outputs unchanged, for example 0x000, 0x800 and 0xFFF.
- R3: Rising serial-clock edges while select is high do not shift. A later load therefore transfers the word received before select went high.
- R4: An address with A1=0 loads both channels, whatever the value of A0.
- R5: Address A1=1, A0=0 loads only channel A. Channel B keeps its code.
- R6: Address A1=1, A0=1 loads only channel B. Channel A keeps its code.
- R7: While the load strobe is low, each addressed output equals the shift register's 12-bit data field. This holds whatever the state of select.
- R8: While the load strobe is high, both outputs hold their codes, including while a new frame is shifted in.
- R9: Rising serial-clock edges while the load strobe is low do not shift, even with select low.
- R10: The address is decoded from the two top bits currently held in the shift register. After a partial or over-long frame, the target and the code follow the shifted contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial-side inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_sel_n | input | 1 | Active-low select for the serial link |
| ld_n | input | 1 | Active-low load strobe; keeps the channel registers open while low |
| code_a | output | 12 | Held code for channel A |
| code_b | output | 12 | Held code for channel B |

## Verification
The shift register can only be seen through a load. A lost, doubled or misplaced bit therefore shows up at the first load strobe after it happens. It appears as a wrong code, or as a load to the wrong channel when the error reaches the address bits. A channel register that opens when it should stay closed changes an output a few system cycles after the strobe falls. The damage then stays visible until the next correct load. The bench checks the outputs while the strobe is low and again after it rises, so a fault in the latch enable is caught inside the same pulse.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   // width of the channel-address prefix carried at the head of each frame
   localparam int unsigned ADDR_W = 2;
   localparam int unsigned NUM_CH = 2;

   typedef enum logic [0:0] {
      CH_A = 1'b0,
      CH_B = 1'b1
   } dacif_ch_e;

   // A1 low selects every channel; with A1 high, A0 selects a single channel
   function automatic logic chan_hit(input logic [ADDR_W-1:0] addr, input dacif_ch_e ch);
      if (!addr[1]) return 1'b1;
      return (addr[0] == logic'(ch));
   endfunction

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
   parameter int unsigned        W       = 1,
   parameter int unsigned        STAGES  = 2,
   parameter logic [W-1:0]       RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dacif_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign dout = pipe[STAGES-1];

endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
   parameter int unsigned FRAME_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_q,
   input  logic               sdat_q,
   input  logic               sel_q,
   input  logic               ld_q,
   output logic [FRAME_W-1:0] word
);

   logic sclk_prev;
   logic sclk_rise;
   logic take_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_q;
   end

   assign sclk_rise = sclk_q & ~sclk_prev;
   // accept a bit only when selected (sel low) and the latches are closed (load high)
   assign take_bit  = sclk_rise & ~sel_q & ld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (take_bit) word <= {word[FRAME_W-2:0], sdat_q};
   end

endmodule

// File: rtl/dacif_chan_reg.sv
module dacif_chan_reg #(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_en,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);

   // clocked model of a level-transparent latch: follows din every cycle it is open
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (open_en) q <= din;
   end

endmodule

// File: rtl/dacif_dual_front.sv
module dacif_dual_front #(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_sel_n,
   input  logic              ld_n,
   output logic [DATA_W-1:0] code_a,
   output logic [DATA_W-1:0] code_b
);
   import dacif_pkg::*;

   localparam int unsigned FRAME_W = ADDR_W + DATA_W;
   localparam int unsigned IN_W    = 4;

   if (DATA_W < 1) begin : g_bad_width
      $error("dacif_dual_front: DATA_W must be positive");
   end
   if (ADDR_W != 2) begin : g_bad_addr
      $error("dacif_dual_front: address prefix must be two bits");
   end

   // synchronized copies; idle levels are clock low, select high, load high
   logic [IN_W-1:0] raw_in;
   logic [IN_W-1:0] sync_in;
   logic            sclk_q, sdat_q, sel_q, ld_q;

   assign raw_in = {ser_clk, ser_dat, ser_sel_n, ld_n};

   dacif_sync #(
      .W       (IN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b0011)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_in),
      .dout  (sync_in)
   );

   assign {sclk_q, sdat_q, sel_q, ld_q} = sync_in;

   logic [FRAME_W-1:0] shreg;

   dacif_shifter #(
      .FRAME_W (FRAME_W)
   ) i_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_q (sclk_q),
      .sdat_q (sdat_q),
      .sel_q  (sel_q),
      .ld_q   (ld_q),
      .word   (shreg)
   );

   logic [ADDR_W-1:0]              addr_now;
   logic [DATA_W-1:0]              data_now;
   logic [NUM_CH-1:0][DATA_W-1:0]  chan_code;

   assign addr_now = shreg[FRAME_W-1 -: ADDR_W];
   assign data_now = shreg[DATA_W-1:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic open_en;
      assign open_en = ~ld_q & chan_hit(addr_now, dacif_ch_e'(c));

      dacif_chan_reg #(
         .DATA_W (DATA_W)
      ) i_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .open_en (open_en),
         .din     (data_now),
         .q       (chan_code[c])
      );
   end

   assign code_a = chan_code[CH_A];
   assign code_b = chan_code[CH_B];

endmodule

// File: rtl/dacif_dual_front_chk.sv
module dacif_dual_front_chk #(
   parameter int unsigned DATA_W  = 12,
   parameter int unsigned FRAME_W = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ld_q,
   input logic               sel_q,
   input logic [FRAME_W-1:0] shreg,
   input logic [DATA_W-1:0]  code_a,
   input logic [DATA_W-1:0]  code_b
);

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_zero_r1: assert (code_a == '0 && code_b == '0)
            else $error("R1: codes not cleared in reset");
      end
   end

   p_deselect_no_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q |=> $stable(shreg));

   p_both_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_q && !shreg[FRAME_W-1]) |=>
         (code_a == $past(shreg[DATA_W-1:0]) && code_b == $past(shreg[DATA_W-1:0])));

   p_b_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_q && shreg[FRAME_W-1 -: 2] == 2'b10) |=> $stable(code_b));

   p_a_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_q && shreg[FRAME_W-1 -: 2] == 2'b11) |=> $stable(code_a));

   p_hold_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_q |=> ($stable(code_a) && $stable(code_b)));

   p_open_no_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_q |=> $stable(shreg));

endmodule

bind dacif_dual_front dacif_dual_front_chk #(
   .DATA_W  (DATA_W),
   .FRAME_W (FRAME_W)
) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ld_q   (ld_q),
   .sel_q  (sel_q),
   .shreg  (shreg),
   .code_a (code_a),
   .code_b (code_b)
);

// File: tb/test_dacif_dual_front.sv
module test_dacif_dual_front;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_dat = 1'b0;
   logic        ser_sel_n = 1'b1;
   logic        ld_n = 1'b1;
   logic [11:0] code_a, code_b;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [11:0] ea;
      logic [11:0] eb;
      string       tag;
   } item_t;

   item_t sb_q[$];
   event  chk_ev;

   // spec-level model of the 14-bit receive word and the expected codes
   logic [13:0] model = '0;
   logic [11:0] exp_a = '0;
   logic [11:0] exp_b = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dacif_dual_front i_dacif_dual_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_clk   (ser_clk),
      .ser_dat   (ser_dat),
      .ser_sel_n (ser_sel_n),
      .ld_n      (ld_n),
      .code_a    (code_a),
      .code_b    (code_b)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input string tag);
      item_t it;
      it.ea  = exp_a;
      it.eb  = exp_b;
      it.tag = tag;
      sb_q.push_back(it);
      -> chk_ev;
      wait_cyc(1);
   endtask

   // monitor: compares queued expectations against the ports
   initial begin
      forever begin
         @(chk_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks += 2;
            if (code_a !== it.ea) begin
               errors++;
               $display("FAIL %s: code_a=%h expected %h", it.tag, code_a, it.ea);
            end
            if (code_b !== it.eb) begin
               errors++;
               $display("FAIL %s: code_b=%h expected %h", it.tag, code_b, it.eb);
            end
         end
      end
   end

   function automatic void apply_open();
      if (!model[13] || !model[12]) exp_a = model[11:0];
      if (!model[13] ||  model[12]) exp_b = model[11:0];
   endfunction

   task automatic send_bit(input logic b);
      ser_dat = b;
      wait_cyc(3);
      ser_clk = 1'b1;
      if (!ser_sel_n && ld_n) model = {model[12:0], b};
      wait_cyc(3);
      ser_clk = 1'b0;
      wait_cyc(2);
   endtask

   task automatic send_frame(input logic [1:0] a, input logic [11:0] d, input bit selected);
      logic [13:0] w;
      w = {a, d};
      if (selected) ser_sel_n = 1'b0;
      wait_cyc(2);
      for (int i = 13; i >= 0; i--) send_bit(w[i]);
      ser_sel_n = 1'b1;
      wait_cyc(2);
   endtask

   task automatic pulse_load(input string tag);
      ld_n = 1'b0;
      apply_open();
      wait_cyc(6);
      push({tag, " (R7 strobe low)"});
      ld_n = 1'b1;
      wait_cyc(6);
      push(tag);
   endtask

   initial begin
      wait_cyc(4);
      push("R1 reset state");
      rst_n = 1'b1;
      wait_cyc(4);
      push("R1 after reset");

      // both channels, midscale; outputs must hold while shifting (R8)
      send_frame(2'b00, 12'h800, 1'b1);
      push("R8 hold while shifting");
      pulse_load("R2 R4 both midscale");

      send_frame(2'b10, 12'hFFF, 1'b1);
      pulse_load("R2 R5 A only full scale");

      send_frame(2'b11, 12'h000, 1'b1);
      pulse_load("R2 R6 B only zero scale");

      send_frame(2'b01, 12'h5A3, 1'b1);
      pulse_load("R4 A0 ignored when A1 low");

      // deselected frame must not enter the shift register
      send_frame(2'b10, 12'h123, 1'b0);
      pulse_load("R3 deselected bits ignored");

      // transparency with select toggling, then edges while open
      send_frame(2'b10, 12'h777, 1'b1);
      ld_n = 1'b0;
      apply_open();
      wait_cyc(6);
      push("R7 open latch follows word");
      ser_sel_n = 1'b0;
      send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b1);
      send_bit(1'b1);
      push("R9 no shift while strobe low");
      ser_sel_n = 1'b1;
      wait_cyc(4);
      push("R7 select high while open");
      ld_n = 1'b1;
      wait_cyc(6);
      pulse_load("R9 word intact after open edges");

      // partial frame: address taken from current top bits
      ser_sel_n = 1'b0;
      wait_cyc(2);
      send_bit(1'b1);
      send_bit(1'b1);
      send_bit(1'b0);
      ser_sel_n = 1'b1;
      wait_cyc(2);
      push("R8 hold after partial frame");
      pulse_load("R10 partial frame decode");

      ser_sel_n = 1'b0;
      wait_cyc(2);
      send_bit(1'b0);
      send_bit(1'b0);
      ser_sel_n = 1'b1;
      wait_cyc(2);
      pulse_load("R10 second partial frame");

      wait_cyc(4);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule